// File: doc/BRIEF.md
# DMA Channel Control and Status Register Slice

This block holds the two 32-bit software-visible words of a single DMA channel: a control word and a status word. Software reaches them through a plain register port that carries a word address, a write enable and a full 32-bit write value; reads are combinational from the addressed word. The block drives the channel's run request, soft-reset request, keyhole and cyclic mode levels and one interrupt line toward the engine and the interrupt fabric.

The block sequences the channel's life cycle against signals from the engine. Run is a software bit that hardware also clears on any error. The halted flag only comes back once the run bit is low and the engine reports that it has fully stopped, so any stopping lag is tolerated. Completion events count down an interrupt threshold, and a coarse delay timer raises its own flag when no new completion arrives within the programmed delay. A soft reset waits for the engine to acknowledge that it has wound down gracefully before it returns every field to its reset value.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word (word address 0) reads 0x0001_0002 and the status word (word address 1) reads 0x0001_0009 with the default build (scatter-gather-present bit 3 set); runOut and irqOut are 0.
- R2: A control write replaces the whole word: bits 3 (keyhole), 4 (cyclic), 14:12 (error, delay, complete interrupt enables), 23:16 (threshold) and 31:24 (delay) take the written value; bits 5–11 and 15 read 0 and bit 1 reads 1 whatever was written.
- R3: Control bit 0 (run) is stored on write; status bit 0 (halted) clears on the second clock edge after run is written 1, and sets on the edge after run is 0 while engStopped is high; while engStopped stays low after a stop, halted stays 0.
- R4: Status bit 1 (idle) reads engIdle when the channel is not halted and 0 whenever halted is 1.
- R5: A pulse on engErr[i] sets a sticky status error bit (engErr[2:0] to status bits 4–6, engErr[5:3] to status bits 8–10), sets the error flag (status bit 14) and clears the run bit on the same edge; halted then follows R3.
- R6: Status bits 12 (complete), 13 (delay) and 14 (error) clear when written 1; writing 0 to them, or writing any other status bit, has no effect.
- R7: Each engDone pulse decrements the live threshold count (status bits 23:16); at a count of 1 the complete flag sets and the count reloads from the threshold field. A control write with a threshold field of 0 keeps the previous threshold.
- R8: After an engDone pulse with a nonzero delay field D, the live delay count (status bits 31:24) rises by one every TICK_LEN cycles and the delay flag sets when it reaches D; a new engDone restarts it from 0.
- R9: Writing control bit 2 raises softRstReq and makes bit 2 read 1; on the following engRstAck pulse every field returns to its R1 value and halted sets.
- R10: irqOut is high exactly while some status flag in bits 14:12 is set together with its enable in control bits 14:12.
- R11: Word addresses other than 0 and 1 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busWordAddr | input | AW | Word address (0 control, 1 status) |
| busWrData | input | 32 | Full write value |
| busRdData | output | 32 | Read value of the addressed word |
| engDone | input | 1 | Completion event pulse from the engine |
| engErr | input | 6 | Error pulses: DMA internal, slave, decode; SG internal, slave, decode |
| engIdle | input | 1 | Engine paused with no queued work |
| engStopped | input | 1 | Engine fully shut down |
| engRstAck | input | 1 | Engine finished graceful soft reset |
| runOut | output | 1 | Run request to the engine |
| softRstReq | output | 1 | Soft reset request to the engine |
| keyholeOut | output | 1 | Fixed-address read mode level |
| cyclicOut | output | 1 | Cyclic descriptor mode level |
| irqOut | output | 1 | Channel interrupt |

## Verification
A wrong run or halted state shows at runOut and status bit 0 within one to two edges of the write or error that should have moved it, so the bench samples those at the exact negedge after each expected edge. A threshold or delay counter that drifts shows first in the live count fields of the status word and then as a complete or delay flag arriving one event or one tick early or late, which the bench brackets with a check before and after the expected edge. A soft reset that misses a field appears as a nonzero difference from the reset words right after the acknowledge.

// File: rtl/dma_chanreg_pkg.sv
package dma_chanreg_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_ERR  = 6;
  localparam int CNT_W    = 8;
  // writable bits of the control word held in storage
  localparam logic [WORD_W-1:0] CFG_MASK  = 32'hFFFF_7018;
  localparam logic [WORD_W-1:0] CFG_RESET = 32'h0001_0000;

  typedef struct packed {
    logic wrCtrl;   // write to control word
    logic wrStat;   // write to status word
    logic softClr;  // graceful soft reset completes
  } regStrobe_t;
endpackage

// File: rtl/chanreg_ctrl.sv
module chanreg_ctrl
  import dma_chanreg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic [AW-1:0] busWordAddr,
  input  logic          wrRunBit,
  input  logic          wrRstBit,
  input  logic [NUM_ERR-1:0] engErr,
  input  logic          engStopped,
  input  logic          engRstAck,
  output regStrobe_t    strb,
  output logic          runBit,
  output logic          halted,
  output logic          rstBusy
);
  logic anyErr;
  assign anyErr = |engErr;

  always_comb begin
    strb.wrCtrl  = busWrEn && (busWordAddr == AW'(0));
    strb.wrStat  = busWrEn && (busWordAddr == AW'(1));
    strb.softClr = rstBusy && engRstAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runBit  <= 1'b0;
      halted  <= 1'b1;
      rstBusy <= 1'b0;
    end else if (strb.softClr) begin
      runBit  <= 1'b0;
      halted  <= 1'b1;
      rstBusy <= 1'b0;
    end else begin
      if (anyErr)           runBit <= 1'b0;
      else if (strb.wrCtrl) runBit <= wrRunBit;
      if (runBit)           halted <= 1'b0;
      else if (engStopped)  halted <= 1'b1;
      if (strb.wrCtrl && wrRstBit) rstBusy <= 1'b1;
    end
  end

  // R3: halted only rises after run was low and the engine reported stopped
  a_r3_halt_lag: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(halted) && !$past(strb.softClr)) |-> (!$past(runBit) && $past(engStopped)));
  // R5: an error removes the run request on the next edge
  a_r5_err_stops_run: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |=> !runBit);
  // R9: acknowledged soft reset leaves the channel stopped and halted
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rstN)
    strb.softClr |=> (!runBit && halted && !rstBusy));
endmodule

// File: rtl/chanreg_data.sv
module chanreg_data
  import dma_chanreg_pkg::*;
#(
  parameter int AW         = 4,
  parameter int TICK_LEN   = 125,
  parameter bit SG_PRESENT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [AW-1:0]      busWordAddr,
  input  logic [WORD_W-1:0]  busWrData,
  input  logic               engDone,
  input  logic [NUM_ERR-1:0] engErr,
  input  logic               engIdle,
  input  logic               runBit,
  input  logic               halted,
  input  logic               rstBusy,
  output logic [WORD_W-1:0]  busRdData,
  output logic               keyholeOut,
  output logic               cyclicOut,
  output logic               irqOut
);
  localparam int TW = (TICK_LEN > 1) ? $clog2(TICK_LEN) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_LEN - 1);

  logic [WORD_W-1:0]  cfg, cfgWr;
  logic [NUM_ERR-1:0] errs;
  logic [2:0]         flags, flagSet;   // {error, delay, complete}
  logic [CNT_W-1:0]   thrCnt, dlyCnt;
  logic [TW-1:0]      tick;
  logic               dlyArmed, iocFire, dlyFire, tickEnd;
  logic [WORD_W-1:0]  ctrlWord, statWord;

  always_comb begin
    cfgWr = busWrData & CFG_MASK;
    if (busWrData[23:16] == '0) cfgWr[23:16] = cfg[23:16];
  end

  assign tickEnd = dlyArmed && (tick == TICK_LAST);
  assign iocFire = engDone && !strb.wrCtrl && (thrCnt == CNT_W'(1));
  assign dlyFire = tickEnd && !engDone && ((dlyCnt + CNT_W'(1)) == cfg[31:24]);
  assign flagSet = {|engErr, dlyFire, iocFire};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= CFG_RESET; errs <= '0; flags <= '0;
      thrCnt <= CNT_W'(1); dlyCnt <= '0; tick <= '0; dlyArmed <= 1'b0;
    end else if (strb.softClr) begin
      cfg <= CFG_RESET; errs <= '0; flags <= '0;
      thrCnt <= CNT_W'(1); dlyCnt <= '0; tick <= '0; dlyArmed <= 1'b0;
    end else begin
      errs  <= errs | engErr;
      flags <= (strb.wrStat ? (flags & ~busWrData[14:12]) : flags) | flagSet;
      // threshold countdown; a control write reloads it and wins
      if (strb.wrCtrl) begin
        cfg    <= cfgWr;
        thrCnt <= cfgWr[23:16];
      end else if (engDone) begin
        thrCnt <= (thrCnt == CNT_W'(1)) ? cfg[23:16] : thrCnt - CNT_W'(1);
      end
      // delay timer, restarted by every completion
      if (engDone) begin
        dlyCnt   <= '0;
        tick     <= '0;
        dlyArmed <= (cfg[31:24] != '0);
      end else if (dlyArmed && cfg[31:24] == '0) begin
        dlyArmed <= 1'b0;
      end else if (tickEnd) begin
        tick   <= '0;
        dlyCnt <= dlyCnt + CNT_W'(1);
        if (dlyFire) dlyArmed <= 1'b0;
      end else if (dlyArmed) begin
        tick <= tick + TW'(1);
      end
    end
  end

  assign ctrlWord = cfg | {29'b0, rstBusy, 1'b1, runBit};
  assign statWord = {dlyCnt, thrCnt, 1'b0, flags, 1'b0, errs[5:3], 1'b0, errs[2:0],
                     SG_PRESENT, 1'b0, engIdle && !halted, halted};

  always_comb begin
    case (busWordAddr)
      AW'(0):  busRdData = ctrlWord;
      AW'(1):  busRdData = statWord;
      default: busRdData = '0;
    endcase
  end

  assign keyholeOut = cfg[3];
  assign cyclicOut  = cfg[4];
  assign irqOut     = |(flags & cfg[14:12]);

  // R7: neither the threshold nor its live count may ever be zero
  a_r7_thresh_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (cfg[23:16] != '0) && (thrCnt != '0));
  // R6: the error flag only rises on an engine error
  a_r6_err_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> $past(|engErr));
  // R5: an error outside soft reset leaves a sticky bit behind
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((|engErr) && !strb.softClr) |=> (errs != '0));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chanreg_pkg::*;
#(
  parameter int AW         = 4,
  parameter int TICK_LEN   = 125,
  parameter bit SG_PRESENT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic [AW-1:0] busWordAddr,
  input  logic [31:0]   busWrData,
  output logic [31:0]   busRdData,
  input  logic          engDone,
  input  logic [5:0]    engErr,
  input  logic          engIdle,
  input  logic          engStopped,
  input  logic          engRstAck,
  output logic          runOut,
  output logic          softRstReq,
  output logic          keyholeOut,
  output logic          cyclicOut,
  output logic          irqOut
);
  regStrobe_t strb;
  logic runBit, halted, rstBusy;

  chanreg_ctrl #(.AW(AW)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busWordAddr(busWordAddr),
    .wrRunBit(busWrData[0]), .wrRstBit(busWrData[2]), .engErr(engErr),
    .engStopped(engStopped), .engRstAck(engRstAck), .strb(strb),
    .runBit(runBit), .halted(halted), .rstBusy(rstBusy)
  );

  chanreg_data #(.AW(AW), .TICK_LEN(TICK_LEN), .SG_PRESENT(SG_PRESENT)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWordAddr(busWordAddr),
    .busWrData(busWrData), .engDone(engDone), .engErr(engErr), .engIdle(engIdle),
    .runBit(runBit), .halted(halted), .rstBusy(rstBusy), .busRdData(busRdData),
    .keyholeOut(keyholeOut), .cyclicOut(cyclicOut), .irqOut(irqOut)
  );

  assign runOut     = runBit;
  assign softRstReq = rstBusy;
endmodule

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  localparam int AW = 4;
  logic clk = 1'b0, rstN = 1'b0, busWrEn = 1'b0;
  logic [AW-1:0] busWordAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic engDone = 0, engIdle = 0, engStopped = 1, engRstAck = 0;
  logic [5:0] engErr = '0;
  logic runOut, softRstReq, keyholeOut, cyclicOut, irqOut;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs #(.AW(AW), .TICK_LEN(125), .SG_PRESENT(1'b1)) dut_i (.*);

  // control writes (run and reset bits kept 0) and expected read-back
  localparam logic [31:0] VEC_W [5] = '{32'h0301_7018, 32'hFFFA_FFFA, 32'h0000_0000,
                                        32'h1002_2008, 32'h0001_0000};
  localparam logic [31:0] VEC_E [5] = '{32'h0301_701A, 32'hFFFA_701A, 32'h00FA_0002,
                                        32'h1002_200A, 32'h0001_0002};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); busWordAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    busWordAddr = a; #0.5; d = busRdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    waitN(3); rstN = 1'b1; waitN(1);
    // R1 reset words
    rd(0, v); chk("R1 ctrl", v, 32'h0001_0002);
    rd(1, v); chk("R1 stat", v, 32'h0001_0009);
    chk("R1 run/irq", {30'b0, runOut, irqOut}, 32'h0);

    // R2 table of control writes
    for (int i = 0; i < 5; i++) begin
      wr(0, VEC_W[i]); rd(0, v); chk($sformatf("R2 vec%0d", i), v, VEC_E[i]);
      if (i == 1) chk("R2 mode outs", {30'b0, keyholeOut, cyclicOut}, 32'h3);
    end
    // R7 zero threshold ignored was in vec2 (kept FA)

    // R3 run/halt handshake
    wr(0, 32'h0001_0001);
    rd(1, v); chk("R3 halted lags run", v & 32'h1, 32'h1);
    chk("R3 runOut", {31'b0, runOut}, 32'h1);
    waitN(1); rd(1, v); chk("R3 halted clears", v & 32'h1, 32'h0);
    engIdle = 1'b1; #0.5; rd(1, v); chk("R4 idle while running", v & 32'h3, 32'h2);
    engStopped = 1'b0;
    wr(0, 32'h0001_0000); waitN(3);
    rd(1, v); chk("R3 halted waits for stop", v & 32'h1, 32'h0);
    engStopped = 1'b1; waitN(1);
    rd(1, v); chk("R3 halted sets", v & 32'h1, 32'h1);
    chk("R4 idle zero when halted", v & 32'h2, 32'h0);
    engIdle = 1'b0;

    // R5 error clears run, halted follows
    wr(0, 32'h0001_0001); waitN(1);
    @(negedge clk); engErr = 6'b010000;
    @(negedge clk); engErr = '0;
    chk("R5 run cleared", {31'b0, runOut}, 32'h0);
    rd(1, v); chk("R5 stat before halt", v, 32'h0001_4208);
    waitN(1); rd(1, v); chk("R5 stat halted", v, 32'h0001_4209);
    chk("R10 irq masked", {31'b0, irqOut}, 32'h0);
    wr(1, 32'h0000_0000); rd(1, v); chk("R6 write 0 no effect", v, 32'h0001_4209);
    wr(0, 32'h0001_4000); chk("R10 irq on enable", {31'b0, irqOut}, 32'h1);
    wr(1, 32'h0000_4000); rd(1, v); chk("R6 w1c error flag", v, 32'h0001_0209);
    chk("R10 irq drops", {31'b0, irqOut}, 32'h0);

    // R7 threshold countdown
    wr(0, 32'h0003_1000); rd(1, v); chk("R7 live thr", v[23:16], 32'h3);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); engDone = 1'b1; @(negedge clk); engDone = 1'b0;
    end
    rd(1, v); chk("R7 after two", v, 32'h0001_0209);
    @(negedge clk); engDone = 1'b1; @(negedge clk); engDone = 1'b0;
    rd(1, v); chk("R7 fire and reload", v, 32'h0003_1209);
    chk("R10 complete irq", {31'b0, irqOut}, 32'h1);
    wr(1, 32'h0000_1000);

    // R8 delay timer, delay 2, threshold 1
    wr(0, 32'h0201_2000);
    @(negedge clk); engDone = 1'b1; @(negedge clk); engDone = 1'b0;
    chk("R8 irq not yet", {31'b0, irqOut}, 32'h0);
    waitN(128); rd(1, v); chk("R8 one tick", v[31:24], 32'h1);
    waitN(110); rd(1, v); chk("R8 flag not early", v & 32'h2000, 32'h0);
    waitN(20);  rd(1, v); chk("R8 flag set", v, 32'h0201_3209);
    chk("R10 delay irq", {31'b0, irqOut}, 32'h1);

    // R9 soft reset
    wr(0, 32'h0000_001C); rd(0, v); chk("R9 busy reads 1", v, 32'h0001_001E);
    waitN(3); chk("R9 req held", {30'b0, softRstReq, keyholeOut}, 32'h3);
    @(negedge clk); engRstAck = 1'b1; @(negedge clk); engRstAck = 1'b0;
    rd(0, v); chk("R9 ctrl restored", v, 32'h0001_0002);
    rd(1, v); chk("R9 stat restored", v, 32'h0001_0009);
    chk("R9 outs low", {28'b0, softRstReq, keyholeOut, irqOut, runOut}, 32'h0);

    // R11 unmapped word
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R11 reads 0", v, 32'h0);
    rd(0, v); chk("R11 ctrl untouched", v, 32'h0001_0002);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule